// File: doc/BRIEF.md
# Center-Aligned Dual-Channel PWM Timer

This block is a 16-bit up/down counter that produces two center-aligned pulse-width modulated outputs. The counter rises from zero to a top value, turns, and falls back to zero. One full period therefore spans twice the top value in counting steps. Each channel compares the shared count against its own active compare value. An output is cleared when the count meets that value on the way up and set when the count meets it on the way down. The result is a pulse that sits symmetrically around the bottom of the period. Either channel can be inverted.

Software writes compare values through a single write port into per-channel holding registers. The active compare value of a channel is refreshed from its holding register only at the instant the count reaches top. A write made at any point in a period therefore never alters that period's waveform. The counter only moves on clock cycles where the `tick` input is high, so an external prescaler sets the PWM rate. The resolution input picks a top of 255, 511 or 1023. Three one-cycle flag outputs mark the bottom of the period and each channel's compare matches.

Top module: `cpwm_timer`

## Requirements
- R1: `res_sel` selects the top value: 0 gives 255, 1 gives 511, 2 and 3 give 1023; one PWM period is 2*top ticks and contains exactly one bottom event.
- R2: Channels A and B each produce their own output from their own compare value; a write with `wr_sel`=0 targets A and `wr_sel`=1 targets B, and a write to one never changes the other's waveform.
- R3: The count rises to top and then falls to zero; a non-inverted pulse is centered on the bottom of the period, so in a window of 2*top ticks starting at top, first plus last high tick index equals 2*top-3.
- R4: A compare write lands in a holding register and becomes active only on the tick where the count reaches top; a write made mid-period leaves that period's high time unchanged and takes effect in the next period.
- R5: In non-inverted mode, with 0 < C < top, the output clears when the count reaches C going up and sets when it reaches C going down, so it is high for 2*C of every 2*top ticks.
- R6: With the channel's invert input high, the output is the complement, high for 2*top-2*C of every 2*top ticks.
- R7: A compare value of 0 holds the non-inverted output low for the whole period; a value equal to or above top holds it high.
- R8: `ovf_flag` pulses high for one clock after the tick on which the count reaches zero while falling.
- R9: A channel's compare flag pulses high for one clock after each tick on which the count equals that channel's active compare value (twice per period for 0 < C < top, once for C of 0 or top, never above top).
- R10: The count, outputs and flags change only in response to cycles with `tick` high; without ticks no flag is raised.
- R11: Synchronous reset clears the count to zero counting up, clears both compare values and holding registers, and drives all outputs and flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; the counter steps on cycles where it is high |
| res_sel | input | 2 | Resolution select (0: 8-bit, 1: 9-bit, 2/3: 10-bit) |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | Compare write target (0: A, 1: B) |
| wr_data | input | 16 | Compare value to write |
| inv_a | input | 1 | Invert output A |
| inv_b | input | 1 | Invert output B |
| pwm_a | output | 1 | PWM output of channel A (registered) |
| pwm_b | output | 1 | PWM output of channel B (registered) |
| cmp_flag_a | output | 1 | Channel A compare-match pulse |
| cmp_flag_b | output | 1 | Channel B compare-match pulse |
| ovf_flag | output | 1 | Bottom-of-period pulse |

## Verification
Every output and flag is registered, so the result of a tick appears one clock after the rising edge that sampled it. A compare write is held until the tick that brings the count to top, which is exactly `top` ticks after reset when counting starts from zero. The bench drives inputs and samples outputs on falling edges. Each sample therefore reflects the rising edge just before it. After each run of `top` ticks that loads the compare values, the bench measures a window of exactly 2*top ticks. High-time counts, pulse centering and flag counts are compared against values derived from the requirements. In the gated-tick test each tick's result is held for two clocks, and the flag check looks at the samples that follow a tick-low edge.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cpwm_dir_e;

  // Top count for a resolution code; codes above 2 saturate at the widest.
  function automatic int unsigned top_count(input logic [1:0] code,
                                            input int unsigned base_bits);
    int unsigned step;
    step = (code == 2'd3) ? 32'd2 : 32'(code);
    return (32'd1 << (base_bits + step)) - 32'd1;
  endfunction

endpackage

// File: rtl/cpwm_updown_counter.sv
module cpwm_updown_counter
  import cpwm_pkg::*;
#(
  parameter int W        = 16,
  parameter int RES_BASE = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   res_sel,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] top,
  output logic [W-1:0] nxt,
  output logic         going_up,
  output logic         hit_top,
  output logic         ovf_flag
);

  cpwm_dir_e dir_q, dir_n;
  logic      hit_zero;

  always_comb begin
    top = W'(top_count(res_sel, RES_BASE));
  end

  always_comb begin
    going_up = (dir_q == DIR_UP);
    if (going_up) begin
      nxt   = (cnt_q >= top) ? top : cnt_q + W'(1);
      dir_n = (nxt == top) ? DIR_DOWN : DIR_UP;
    end else begin
      nxt   = (cnt_q == '0) ? '0 : cnt_q - W'(1);
      dir_n = (nxt == '0) ? DIR_UP : DIR_DOWN;
    end
    hit_top  = going_up && (nxt == top);
    hit_zero = !going_up && (nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      dir_q    <= DIR_UP;
      ovf_flag <= 1'b0;
    end else begin
      ovf_flag <= tick && hit_zero;
      if (tick) begin
        cnt_q <= nxt;
        dir_q <= dir_n;
      end
    end
  end

  // R10: no movement of the count without a tick
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // R8: bottom flag only ever accompanies a zero count
  assert_ovf_bottom_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (cnt_q == '0));

  // R10: a flag only follows a ticked cycle
  assert_ovf_tick_R10: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !ovf_flag);

  // R1: with a fixed resolution the count stays within top
  assert_range_R1: assert property (@(posedge clk) disable iff (rst)
    ($stable(res_sel) && ($past(cnt_q) <= $past(top))) |-> (cnt_q <= top));

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         going_up,
  input  logic         hit_top,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] top,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         invert,
  output logic         pwm_q,
  output logic         flag_q
);

  logic [W-1:0] hold_q;
  logic [W-1:0] act_q;
  logic [W-1:0] cmp_eff;
  logic         lvl_q, lvl_n;

  // On the top-reaching tick the newly loaded value already governs.
  always_comb begin
    cmp_eff = hit_top ? hold_q : act_q;
    lvl_n   = lvl_q;
    if (step) begin
      if (cmp_eff == '0)       lvl_n = 1'b0;
      else if (cmp_eff >= top) lvl_n = 1'b1;
      else if (nxt == cmp_eff) lvl_n = !going_up;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      act_q  <= '0;
      lvl_q  <= 1'b0;
      pwm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_hit) hold_q <= wr_data;
      if (step && hit_top) act_q <= hold_q;
      lvl_q  <= lvl_n;
      pwm_q  <= lvl_n ^ invert;
      flag_q <= step && (nxt == cmp_eff);
    end
  end

  // R7: zero compare keeps the level low
  assert_zero_low_R7: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0) |-> !lvl_q);

  // R7: compare at or above top keeps the level high
  assert_full_high_R7: assert property (@(posedge clk) disable iff (rst)
    ($stable(top) && (act_q >= top) && (act_q != '0)) |-> lvl_q);

  // R9: a match flag implies the count sits on the active compare
  assert_flag_match_R9: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> (cnt_q == act_q));

  // R4: the active compare changes only as the count lands on top
  assert_load_top_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> (cnt_q == top));

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
  parameter int W        = 16,
  parameter int RES_BASE = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   res_sel,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         inv_a,
  input  logic         inv_b,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         cmp_flag_a,
  output logic         cmp_flag_b,
  output logic         ovf_flag
);

  localparam int NCH = 2;

  logic [W-1:0]   cnt_q, top, nxt;
  logic           going_up, hit_top;
  logic [NCH-1:0] inv_v, pwm_v, flag_v;

  assign inv_v = {inv_b, inv_a};

  cpwm_updown_counter #(.W(W), .RES_BASE(RES_BASE)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .res_sel  (res_sel),
    .cnt_q    (cnt_q),
    .top      (top),
    .nxt      (nxt),
    .going_up (going_up),
    .hit_top  (hit_top),
    .ovf_flag (ovf_flag)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    cpwm_channel #(.W(W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .step     (tick),
      .going_up (going_up),
      .hit_top  (hit_top),
      .nxt      (nxt),
      .cnt_q    (cnt_q),
      .top      (top),
      .wr_hit   (wr_en && (wr_sel == 1'(ch))),
      .wr_data  (wr_data),
      .invert   (inv_v[ch]),
      .pwm_q    (pwm_v[ch]),
      .flag_q   (flag_v[ch])
    );
  end

  assign pwm_a      = pwm_v[0];
  assign pwm_b      = pwm_v[1];
  assign cmp_flag_a = flag_v[0];
  assign cmp_flag_b = flag_v[1];

endmodule

// File: tb/sim_cpwm_timer.sv
module sim_cpwm_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        inv_a = 1'b0;
  logic        inv_b = 1'b0;
  logic        pwm_a, pwm_b, cmp_flag_a, cmp_flag_b, ovf_flag;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cpwm_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .res_sel(res_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .inv_a(inv_a), .inv_b(inv_b), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .cmp_flag_a(cmp_flag_a), .cmp_flag_b(cmp_flag_b), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic [1:0]  res;
    logic        ia;
    logic        ib;
    logic [15:0] ca;
    logic [15:0] cb;
    logic [15:0] ea;
    logic [15:0] eb;
    logic [3:0]  fa;
    logic [3:0]  fb;
  } vec_t;

  // res, invA, invB, cmpA, cmpB, high ticks A, high ticks B, flags A, flags B
  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 1'b0, 16'd100,  16'd200,  16'd200,  16'd400,  4'd2, 4'd2},
    '{2'd1, 1'b0, 1'b0, 16'd0,    16'd511,  16'd0,    16'd1022, 4'd1, 4'd1},
    '{2'd2, 1'b1, 1'b0, 16'd300,  16'd1,    16'd1446, 16'd2,    4'd2, 4'd2},
    '{2'd3, 1'b1, 1'b0, 16'd1023, 16'd2000, 16'd0,    16'd2046, 4'd1, 4'd0},
    '{2'd0, 1'b0, 1'b1, 16'd254,  16'd1,    16'd508,  16'd508,  4'd2, 4'd2},
    '{2'd1, 1'b0, 1'b1, 16'd256,  16'd256,  16'd512,  16'd510,  4'd2, 4'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int top_of(input logic [1:0] r);
    return (1 << (8 + ((r == 2'd3) ? 2 : int'(r)))) - 1;
  endfunction

  task automatic start(input logic [1:0] r, input logic ia, input logic ib,
                       input logic [15:0] ca, input logic [15:0] cb);
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0;
    res_sel = r; inv_a = ia; inv_b = ib;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = ca;
    @(negedge clk);
    wr_sel = 1'b1; wr_data = cb;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Samples n ticks; optionally writes channel A after sample wr_at.
  task automatic measure(input int n, input int wr_at, input logic [15:0] wr_val,
                         output int ha, output int hb, output int fa,
                         output int fb, output int ov,
                         output int first_a, output int last_a);
    ha = 0; hb = 0; fa = 0; fb = 0; ov = 0; first_a = -1; last_a = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pwm_a) begin
        if (first_a < 0) first_a = i;
        last_a = i;
        ha++;
      end
      if (pwm_b) hb++;
      if (cmp_flag_a) fa++;
      if (cmp_flag_b) fb++;
      if (ovf_flag) ov++;
      if (i == wr_at) begin
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = wr_val;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ha, hb, fa, fb, ov, fst, lst, tp, viol;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 pwm_a in reset", int'(pwm_a), 0);
    chk("R11 pwm_b in reset", int'(pwm_b), 0);
    chk("R11 flags in reset", int'(cmp_flag_a | cmp_flag_b | ovf_flag), 0);

    // R10: no ticks, no flags and no output movement
    start(2'd0, 1'b0, 1'b0, 16'd100, 16'd0);
    viol = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_a | pwm_b | cmp_flag_a | cmp_flag_b | ovf_flag) viol++;
    end
    chk("R10 idle without tick", viol, 0);

    // Table walk: R1 R2 R3 R5 R6 R7 R8 R9
    foreach (VECS[k]) begin
      tp = top_of(VECS[k].res);
      start(VECS[k].res, VECS[k].ia, VECS[k].ib, VECS[k].ca, VECS[k].cb);
      tick = 1'b1;
      repeat (tp) @(negedge clk);
      measure(2 * tp, -1, '0, ha, hb, fa, fb, ov, fst, lst);
      chk($sformatf("R5/R6/R7 vec%0d high ticks A", k), ha, int'(VECS[k].ea));
      chk($sformatf("R2/R5/R6/R7 vec%0d high ticks B", k), hb, int'(VECS[k].eb));
      chk($sformatf("R9 vec%0d flags A", k), fa, int'(VECS[k].fa));
      chk($sformatf("R9 vec%0d flags B", k), fb, int'(VECS[k].fb));
      chk($sformatf("R1/R8 vec%0d bottom pulses", k), ov, 1);
      if (!VECS[k].ia && VECS[k].ca != 0 && int'(VECS[k].ca) < tp)
        chk($sformatf("R3 vec%0d centering", k), fst + lst, 2 * tp - 3);
      tick = 1'b0;
    end

    // R4: mid-period write does not disturb the current period
    start(2'd0, 1'b0, 1'b0, 16'd100, 16'd0);
    tick = 1'b1;
    repeat (255) @(negedge clk);
    measure(510, 50, 16'd20, ha, hb, fa, fb, ov, fst, lst);
    chk("R4 current period keeps old compare", ha, 200);
    chk("R2 channel B untouched by A write", hb, 0);
    measure(510, -1, '0, ha, hb, fa, fb, ov, fst, lst);
    chk("R4 next period uses new compare", ha, 40);
    chk("R3 centering after reload", fst + lst, 2 * 255 - 3);
    tick = 1'b0;

    // R10: tick on alternate cycles stretches each step over two clocks
    start(2'd0, 1'b0, 1'b0, 16'd100, 16'd0);
    tick = 1'b1;
    for (int i = 0; i < 510; i++) begin
      @(negedge clk);
      tick = ~tick;
    end
    ha = 0; ov = 0; viol = 0;
    for (int i = 0; i < 1020; i++) begin
      logic prev;
      @(negedge clk);
      prev = tick;
      if (pwm_a) ha++;
      if (ovf_flag) ov++;
      if (!prev && (cmp_flag_a | ovf_flag)) viol++;
      tick = ~tick;
    end
    chk("R10 gated high clocks", ha, 400);
    chk("R10 gated bottom pulses", ov, 1);
    chk("R10 no flag after tick-low edge", viol, 0);
    tick = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule